// File: doc/BRIEF.md
# DMX512 Channel Window Receiver

This block takes the receive line of a DMX512 lighting link, already synchronised to the local clock, and pulls a window of channel levels out of each packet. A low-level watchdog samples the line at a fixed interval and declares a packet boundary (break) once the line has stayed low long enough. Only then is the byte receiver switched on. The receiver decodes 8-bit slots with two stop bits at 250 kbit/s. It checks the first slot, which is the start code, and then counts the data slots that follow.

The user chooses the window with a start address and a channel count. Data slots whose index is above the start address are written one after another into a small bank of channel registers, and the bank drives the outputs directly. When the requested count is stored, or the packet slot limit is reached, the block pulses a done flag. It then returns to hunting for the next break. A malformed slot (low stop bit) pulses an error flag and also sends the block back to hunting.

Top module: `dmx_slot_rx`

## Requirements
- R1: After reset every channel output byte is 0x00, frame_done and frame_err are low, and the block is waiting for a break.
- R2: The line is sampled once every CLK_HZ/SAMPLE_HZ cycles. A break is declared after BREAK_SAMPLES consecutive low samples. Any high sample clears the run, so two low stretches split by a high gap do not form a break.
- R3: Slots are decoded only after a break. Slots that arrive while the block hunts for a break change no channel value and raise no flag. Break sampling is off while slots are being decoded.
- R4: A slot is one low start bit, eight data bits sent least significant bit first, and high stop bits. The bit period is CLK_HZ/BAUD cycles, and each bit is sampled at its middle.
- R5: The first slot after a break is the start code. A value of 0x00 is discarded and never stored. Any other value causes the rest of the packet to be ignored until the next break, with no done pulse.
- R6: Data slot n (counted from 1 after the start code) is stored in channel position n - start_addr - 1 only when n > start_addr. Position 0 is chan_vals[7:0].
- R7: frame_done pulses for one cycle once the effective count of channels is stored. The effective count is chan_count, or NCH when chan_count is 0 or above NCH. Slots after that point in the same packet are not stored.
- R8: When data slot MAX_SLOTS arrives, frame_done pulses even if fewer channels were stored, and capture ends.
- R9: A slot whose first stop bit samples low pulses frame_err for one cycle and ends capture without a done pulse. Values stored earlier in that packet are kept, and the next break starts a fresh capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Synchronised DMX receive line, idle high |
| start_addr | input | clog2(MAX_SLOTS+1) | Number of data slots skipped before the window |
| chan_count | input | clog2(NCH+1) | Channels to capture (0 or above NCH means NCH) |
| chan_vals | output | NCH*8 | Captured channel bytes, position 0 in the low byte |
| frame_done | output | 1 | One-cycle pulse when the window is complete |
| frame_err | output | 1 | One-cycle pulse on a framing error |

## Verification
The bench builds the block with a 4 MHz nominal clock rate, so a bit lasts 16 cycles and a break needs 320 cycles of low. It also uses a four-channel bank and a packet limit of twelve slots. These values make a full packet short enough that the bench can run to the slot limit, go past the bank size with the count clamp, and place a window at the very end of a packet within a few thousand cycles. The break threshold and bit timing keep the same ratios as a full-rate link.

// File: rtl/dmx_rx_pkg.sv
package dmx_rx_pkg;

    typedef enum logic [1:0] {
        SEEK_BREAK = 2'd0,
        GET_START  = 2'd1,
        GET_SLOTS  = 2'd2
    } ctrl_state_t;

    typedef enum logic [2:0] {
        U_ARM   = 3'd0,
        U_IDLE  = 3'd1,
        U_START = 3'd2,
        U_DATA  = 3'd3,
        U_STOP  = 3'd4
    } uart_state_t;

    typedef struct packed {
        logic       valid;
        logic       ferr;
        logic [7:0] data;
    } slot_evt_t;

    localparam logic [7:0] NULL_START_CODE = 8'h00;

    function automatic int unsigned clk_ratio(input int unsigned fast_hz,
                                              input int unsigned slow_hz);
        return (fast_hz + slow_hz / 2) / slow_hz;
    endfunction

endpackage

// File: rtl/dmx_break_det.sv
module dmx_break_det #(
    parameter int unsigned SAMPLE_CLKS   = 200,
    parameter int unsigned BREAK_SAMPLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic rx,
    output logic brk
);
    localparam int TW = $clog2(SAMPLE_CLKS + 1);
    localparam int RW = $clog2(BREAK_SAMPLES + 1);

    logic [TW-1:0] tick_cnt;
    logic [RW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            tick_cnt <= '0;
            low_run  <= '0;
            brk      <= 1'b0;
        end else begin
            brk <= 1'b0;
            if (tick_cnt == TW'(SAMPLE_CLKS - 1)) begin
                tick_cnt <= '0;
                if (rx) begin
                    low_run <= '0;
                end else if (low_run == RW'(BREAK_SAMPLES - 1)) begin
                    brk     <= 1'b1;
                    low_run <= '0;
                end else begin
                    low_run <= low_run + RW'(1);
                end
            end else begin
                tick_cnt <= tick_cnt + TW'(1);
            end
        end
    end

    // R2: a break is only declared on a low sample
    a_r2_brk_on_low: assert property (@(posedge clk) disable iff (rst)
        brk |-> $past(!rx));

endmodule

// File: rtl/dmx_slot_uart.sv
module dmx_slot_uart
    import dmx_rx_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = 200
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      rx,
    output slot_evt_t evt
);
    localparam int CW   = $clog2(CLKS_PER_BIT + 1);
    localparam int HALF = CLKS_PER_BIT / 2;

    uart_state_t st;
    logic [CW-1:0] cnt;
    logic [2:0]    bit_i;
    logic [7:0]    shreg;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st    <= U_ARM;
            cnt   <= '0;
            bit_i <= '0;
            shreg <= '0;
            evt   <= '0;
        end else begin
            evt.valid <= 1'b0;
            evt.ferr  <= 1'b0;
            case (st)
                U_ARM: begin
                    if (rx) st <= U_IDLE;
                end
                U_IDLE: begin
                    if (!rx) begin
                        st  <= U_START;
                        cnt <= '0;
                    end
                end
                U_START: begin
                    if (cnt == CW'(HALF - 1)) begin
                        cnt <= '0;
                        if (rx) begin
                            st <= U_IDLE;
                        end else begin
                            st    <= U_DATA;
                            bit_i <= '0;
                        end
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                U_DATA: begin
                    if (cnt == CW'(CLKS_PER_BIT - 1)) begin
                        cnt   <= '0;
                        shreg <= {rx, shreg[7:1]};
                        if (bit_i == 3'd7) st <= U_STOP;
                        else bit_i <= bit_i + 3'd1;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                U_STOP: begin
                    if (cnt == CW'(CLKS_PER_BIT - 1)) begin
                        cnt      <= '0;
                        evt.data <= shreg;
                        if (rx) begin
                            evt.valid <= 1'b1;
                            st        <= U_IDLE;
                        end else begin
                            evt.ferr <= 1'b1;
                            st       <= U_ARM;
                        end
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: st <= U_ARM;
            endcase
        end
    end

    // R9: a slot is either good or malformed, never both
    a_r9_evt_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(evt.valid && evt.ferr));

    // R4: one slot event per decoded slot
    a_r4_evt_single: assert property (@(posedge clk) disable iff (rst)
        evt.valid |=> !evt.valid);

endmodule

// File: rtl/dmx_slot_ctrl.sv
module dmx_slot_ctrl
    import dmx_rx_pkg::*;
#(
    parameter int unsigned NCH       = 16,
    parameter int unsigned MAX_SLOTS = 512,
    parameter int unsigned SLOT_W    = 10,
    parameter int unsigned CNT_W     = 5,
    parameter int unsigned IW        = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              brk,
    input  slot_evt_t         evt,
    input  logic [SLOT_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  chan_count,
    output logic              brk_en,
    output logic              uart_en,
    output logic              wr_en,
    output logic [IW-1:0]     wr_idx,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic              ferr_o
);
    ctrl_state_t       state;
    logic [SLOT_W-1:0] slot_idx;
    logic [SLOT_W-1:0] nxt_idx;
    logic [SLOT_W-1:0] pos;
    logic [CNT_W-1:0]  stored;
    logic [CNT_W-1:0]  eff;
    logic              in_win;
    logic              last_ch;
    logic              last_slot;

    always_comb begin
        eff = chan_count;
        if (chan_count == '0 || chan_count > CNT_W'(NCH)) eff = CNT_W'(NCH);
        nxt_idx   = slot_idx + SLOT_W'(1);
        in_win    = nxt_idx > start_addr;
        pos       = slot_idx - start_addr;
        last_ch   = in_win && (stored + CNT_W'(1) == eff);
        last_slot = nxt_idx == SLOT_W'(MAX_SLOTS);
    end

    assign brk_en  = state == SEEK_BREAK;
    assign uart_en = state != SEEK_BREAK;
    assign wr_en   = (state == GET_SLOTS) && evt.valid && in_win;
    assign wr_idx  = pos[IW-1:0];
    assign wr_data = evt.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEEK_BREAK;
            slot_idx <= '0;
            stored   <= '0;
            done     <= 1'b0;
            ferr_o   <= 1'b0;
        end else begin
            done   <= 1'b0;
            ferr_o <= 1'b0;
            case (state)
                SEEK_BREAK: begin
                    if (brk) begin
                        state    <= GET_START;
                        slot_idx <= '0;
                        stored   <= '0;
                    end
                end
                GET_START: begin
                    if (evt.ferr) begin
                        ferr_o <= 1'b1;
                        state  <= SEEK_BREAK;
                    end else if (evt.valid) begin
                        if (evt.data == NULL_START_CODE) state <= GET_SLOTS;
                        else state <= SEEK_BREAK;
                    end
                end
                GET_SLOTS: begin
                    if (evt.ferr) begin
                        ferr_o <= 1'b1;
                        state  <= SEEK_BREAK;
                    end else if (evt.valid) begin
                        slot_idx <= nxt_idx;
                        if (in_win) stored <= stored + CNT_W'(1);
                        if (last_ch || last_slot) begin
                            done  <= 1'b1;
                            state <= SEEK_BREAK;
                        end
                    end
                end
                default: state <= SEEK_BREAK;
            endcase
        end
    end

    // R7: the done flag is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: the slot counter never passes the packet limit
    a_r8_idx_bound: assert property (@(posedge clk) disable iff (rst)
        slot_idx <= SLOT_W'(MAX_SLOTS));

    // R7: never more channels stored than the bank holds
    a_r7_stored_bound: assert property (@(posedge clk) disable iff (rst)
        stored <= CNT_W'(NCH));

    // R9: an aborted packet never also completes
    a_r9_err_no_done: assert property (@(posedge clk) disable iff (rst)
        ferr_o |-> !done);

endmodule

// File: rtl/dmx_chan_bank.sv
module dmx_chan_bank #(
    parameter int unsigned NCH = 16,
    parameter int unsigned IW  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [7:0]       wr_data,
    output logic [NCH*8-1:0] vals
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [7:0] level;
        always_ff @(posedge clk) begin
            if (rst) level <= 8'h00;
            else if (wr_en && wr_idx == IW'(g)) level <= wr_data;
        end
        assign vals[g*8 +: 8] = level;
    end

    // R1: bank is cleared on the cycle after reset
    a_r1_bank_clear: assert property (@(posedge clk)
        $past(rst) |-> vals == '0);

endmodule

// File: rtl/dmx_slot_rx.sv
module dmx_slot_rx
    import dmx_rx_pkg::*;
#(
    parameter int unsigned CLK_HZ        = 50_000_000,
    parameter int unsigned BAUD          = 250_000,
    parameter int unsigned SAMPLE_HZ     = 250_000,
    parameter int unsigned BREAK_SAMPLES = 20,
    parameter int unsigned MAX_SLOTS     = 512,
    parameter int unsigned NCH           = 16
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               rx_line,
    input  logic [$clog2(MAX_SLOTS+1)-1:0]     start_addr,
    input  logic [$clog2(NCH+1)-1:0]           chan_count,
    output logic [NCH*8-1:0]                   chan_vals,
    output logic                               frame_done,
    output logic                               frame_err
);
    localparam int unsigned SLOT_W      = $clog2(MAX_SLOTS + 1);
    localparam int unsigned CNT_W       = $clog2(NCH + 1);
    localparam int unsigned IW          = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int unsigned BIT_CLKS    = clk_ratio(CLK_HZ, BAUD);
    localparam int unsigned SAMPLE_CLKS = clk_ratio(CLK_HZ, SAMPLE_HZ);

    logic          brk, brk_en, uart_en, wr_en;
    logic [IW-1:0] wr_idx;
    logic [7:0]    wr_data;
    slot_evt_t     evt;

    dmx_break_det #(
        .SAMPLE_CLKS  (SAMPLE_CLKS),
        .BREAK_SAMPLES(BREAK_SAMPLES)
    ) u_brk (
        .clk(clk), .rst(rst), .en(brk_en), .rx(rx_line), .brk(brk)
    );

    dmx_slot_uart #(
        .CLKS_PER_BIT(BIT_CLKS)
    ) u_uart (
        .clk(clk), .rst(rst), .en(uart_en), .rx(rx_line), .evt(evt)
    );

    dmx_slot_ctrl #(
        .NCH(NCH), .MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W),
        .CNT_W(CNT_W), .IW(IW)
    ) u_ctrl (
        .clk(clk), .rst(rst), .brk(brk), .evt(evt),
        .start_addr(start_addr), .chan_count(chan_count),
        .brk_en(brk_en), .uart_en(uart_en), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data),
        .done(frame_done), .ferr_o(frame_err)
    );

    dmx_chan_bank #(
        .NCH(NCH), .IW(IW)
    ) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .vals(chan_vals)
    );

    // R3: a break is never declared while slots are being decoded
    a_r3_no_brk_in_capture: assert property (@(posedge clk) disable iff (rst)
        uart_en |-> !brk);

endmodule

// File: tb/tb_dmx_slot_rx.sv
module tb_dmx_slot_rx;
    localparam int BIT = 16;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_line = 1'b1;
    logic [3:0]  start_addr = '0;
    logic [2:0]  chan_count = 3'd4;
    logic [31:0] chan_vals;
    logic        frame_done, frame_err;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int err_cnt = 0;

    always #5 clk = ~clk;

    dmx_slot_rx #(
        .CLK_HZ(4_000_000), .BAUD(250_000), .SAMPLE_HZ(250_000),
        .BREAK_SAMPLES(20), .MAX_SLOTS(12), .NCH(NCH)
    ) dut (
        .clk(clk), .rst(rst), .rx_line(rx_line), .start_addr(start_addr),
        .chan_count(chan_count), .chan_vals(chan_vals),
        .frame_done(frame_done), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (frame_done) done_cnt++;
            if (frame_err) err_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_ch(input int idx, input logic [7:0] exp, input string req);
        chk(chan_vals[idx*8 +: 8] == exp, req, int'(chan_vals[idx*8 +: 8]), int'(exp));
    endtask

    task automatic hold(input logic v, input int cycles);
        rx_line = v;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic send_break(input int samples);
        hold(1'b0, samples * BIT);
        hold(1'b1, 2 * BIT);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit good_stop);
        hold(1'b0, BIT);
        for (int i = 0; i < 8; i++) hold(b[i], BIT);
        hold(good_stop, BIT);
        hold(1'b1, BIT);
    endtask

    task automatic settle();
        hold(1'b1, 20);
    endtask

    task automatic t_reset();
        chk(chan_vals == 32'h0, "R1 bank clear", int'(chan_vals), 0);
        chk(done_cnt == 0 && err_cnt == 0, "R1 flags low", done_cnt + err_cnt, 0);
    endtask

    task automatic t_basic();
        int d0 = done_cnt;
        start_addr = 4'd0; chan_count = 3'd4;
        send_break(25);
        send_byte(8'h00, 1'b1);
        send_byte(8'hA1, 1'b1); send_byte(8'hB2, 1'b1);
        send_byte(8'hC3, 1'b1); send_byte(8'hD4, 1'b1);
        settle();
        chk_ch(0, 8'hA1, "R4 slot1"); chk_ch(1, 8'hB2, "R4 slot2");
        chk_ch(2, 8'hC3, "R6 slot3"); chk_ch(3, 8'hD4, "R6 slot4");
        chk(done_cnt == d0 + 1, "R7 done once", done_cnt - d0, 1);
    endtask

    task automatic t_offset();
        int d0 = done_cnt;
        start_addr = 4'd2; chan_count = 3'd2;
        send_break(25);
        send_byte(8'h00, 1'b1);
        send_byte(8'h11, 1'b1); send_byte(8'h22, 1'b1);
        send_byte(8'h33, 1'b1); send_byte(8'h44, 1'b1);
        send_byte(8'h55, 1'b1);
        settle();
        chk_ch(0, 8'h33, "R6 window pos0"); chk_ch(1, 8'h44, "R6 window pos1");
        chk_ch(2, 8'hC3, "R7 no store after count");
        chk(done_cnt == d0 + 1, "R7 done offset", done_cnt - d0, 1);
    endtask

    task automatic t_bad_start();
        int d0 = done_cnt;
        start_addr = 4'd0; chan_count = 3'd4;
        send_break(25);
        send_byte(8'h17, 1'b1);
        for (int i = 0; i < 4; i++) send_byte(8'h99, 1'b1);
        settle();
        chk_ch(0, 8'h33, "R5 nonzero start ignored");
        chk(done_cnt == d0, "R5 no done", done_cnt - d0, 0);
    endtask

    task automatic t_short_low();
        int d0 = done_cnt;
        hold(1'b0, 15 * BIT); hold(1'b1, 3 * BIT);
        hold(1'b0, 15 * BIT); hold(1'b1, 3 * BIT);
        send_byte(8'h00, 1'b1);
        for (int i = 0; i < 4; i++) send_byte(8'hEE, 1'b1);
        settle();
        chk_ch(0, 8'h33, "R2 split low no break");
        chk_ch(1, 8'h44, "R3 no capture without break");
        chk(done_cnt == d0, "R3 no done", done_cnt - d0, 0);
    endtask

    task automatic t_frame_err();
        int d0 = done_cnt;
        int e0 = err_cnt;
        start_addr = 4'd0; chan_count = 3'd4;
        send_break(25);
        send_byte(8'h00, 1'b1);
        send_byte(8'h5A, 1'b1);
        send_byte(8'h77, 1'b0);
        send_byte(8'h88, 1'b1);
        settle();
        chk(err_cnt == e0 + 1, "R9 err pulse", err_cnt - e0, 1);
        chk_ch(0, 8'h5A, "R9 prior kept");
        chk_ch(1, 8'h44, "R9 bad slot not stored");
        chk(done_cnt == d0, "R9 no done", done_cnt - d0, 0);
    endtask

    task automatic t_limit();
        int d0 = done_cnt;
        start_addr = 4'd9; chan_count = 3'd4;
        send_break(25);
        send_byte(8'h00, 1'b1);
        for (int i = 1; i <= 13; i++) send_byte(8'(i), 1'b1);
        settle();
        chk_ch(0, 8'h0A, "R8 slot10"); chk_ch(2, 8'h0C, "R8 slot12");
        chk_ch(3, 8'hD4, "R8 slot13 dropped");
        chk(done_cnt == d0 + 1, "R8 done at limit", done_cnt - d0, 1);
    endtask

    task automatic t_clamp();
        int d0 = done_cnt;
        start_addr = 4'd0; chan_count = 3'd7;
        send_break(25);
        send_byte(8'h00, 1'b1);
        for (int i = 1; i <= 5; i++) send_byte(8'(i), 1'b1);
        settle();
        chk_ch(3, 8'h04, "R7 clamp fills bank");
        chk(done_cnt == d0 + 1, "R7 clamp done", done_cnt - d0, 1);
        chan_count = 3'd0;
        send_break(25);
        send_byte(8'h00, 1'b1);
        send_byte(8'h10, 1'b1); send_byte(8'h20, 1'b1);
        send_byte(8'h30, 1'b1); send_byte(8'h40, 1'b1);
        settle();
        chk_ch(3, 8'h40, "R7 zero count means all");
        chk(done_cnt == d0 + 2, "R7 zero count done", done_cnt - d0, 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle();
        t_reset();
        t_basic();
        t_offset();
        t_bad_start();
        t_short_low();
        t_frame_err();
        t_limit();
        t_clamp();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule